// File: doc/BRIEF.md
# Clause-Boundary Group Scheduler

This block tracks up to eight resident four-lane thread groups for one execution engine and decides which of them the engine runs. Each group keeps one program counter, since its four lanes advance in lock-step. A group also has a resident flag and a stalled flag. The engine runs exactly one group at a time. The scheduler may replace that group only when the engine reports that a clause has finished.

Each group has a stall input and a wake input. The stall input marks a group whose next clause is waiting on something outside the engine, such as a memory response. The wake input clears that mark. At a clause boundary the scheduler applies all flag changes from the same cycle. It then picks the next group by rotating priority, starting at the index after the running group. A stalled group is therefore left at its boundary and a ready group is taken instead. If nothing can run, the block signals idle and issues nothing. A new group is made resident through a launch port that gives its starting program counter.

Top module: `quad_sched`

## Requirements
- R1: After reset no group is resident, `run_valid` is 0, `idle` is 1 and `run_pc` is 0.
- R2: A launch to a non-resident group makes it resident and not stalled, with `launch_pc` as its program counter, from the next cycle. A launch to a group that is already resident is ignored, including its program counter.
- R3: A stall pulse for a group marks it stalled from the next cycle. A wake pulse clears the mark from the next cycle. When both arrive in the same cycle, the wake wins.
- R4: While a group runs and `clause_done` is low, `run_id` and `run_pc` hold their values, even if that group is stalled.
- R5: On `clause_done`, the running group's program counter becomes `done_pc`. If `done_exit` is also 1, the group stops being resident and its slot can be launched again.
- R6: At a clause boundary the next group is the first eligible index after the running one, in ascending order with wrap-around. A group is eligible when it is resident and not stalled, with the same cycle's launch, stall, wake and exit already applied. The new choice appears on the outputs one cycle after `clause_done`.
- R7: When the running group is the only eligible group at its boundary, it runs again from the next cycle with its updated program counter.
- R8: When no group is eligible, `run_valid` is 0, `idle` is 1 and `run_pc` is 0. While idle, the first cycle in which a group becomes eligible causes that group to be selected on the next cycle, using the same rotating order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_en | input | 1 | Make group `launch_id` resident |
| launch_id | input | 3 | Group slot to launch |
| launch_pc | input | 32 | Starting program counter for the launched group |
| stall_req | input | 8 | Per-group pulse: next clause waits on an external resource |
| wake_req | input | 8 | Per-group pulse: the awaited resource has arrived |
| clause_done | input | 1 | The running group finished its current clause |
| done_pc | input | 32 | Program counter after the finished clause |
| done_exit | input | 1 | With `clause_done`: the running group has terminated |
| run_valid | output | 1 | A group is selected |
| run_id | output | 3 | Selected group |
| run_pc | output | 32 | Program counter of the selected group, 0 when idle |
| idle | output | 1 | No group is selected |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. This holds for a launch, a stall or wake pulse, and a `clause_done` with or without exit. It holds both for the rebalanced choice after a boundary and for leaving or entering idle. The driver applies one cycle of stimulus on the falling edge and queues the output value expected after the next rising edge. The monitor samples one nanosecond after that rising edge and compares. Cycles with no stimulus are also queued, so any change in the selection or the program counter during a clause shows up as a mismatch.

// File: rtl/qs_pkg.sv
package qs_pkg;

   typedef enum logic [0:0] {
      PICK_ROTATE = 1'b0,
      PICK_LOWEST = 1'b1
   } pick_mode_e;

endpackage

// File: rtl/qs_group_table.sv
module qs_group_table #(
   parameter int N_GRP = 8,
   parameter int PC_W  = 32,
   localparam int ID_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       launch_en,
   input  logic [ID_W-1:0]            launch_id,
   input  logic [PC_W-1:0]            launch_pc,
   input  logic [N_GRP-1:0]           stall_req,
   input  logic [N_GRP-1:0]           wake_req,
   input  logic                       done_en,
   input  logic [ID_W-1:0]            done_id,
   input  logic [PC_W-1:0]            done_pc,
   input  logic                       done_exit,
   output logic [N_GRP-1:0]           valid_q,
   output logic [N_GRP-1:0][PC_W-1:0] pc_q,
   output logic [N_GRP-1:0]           elig_nxt
);

   logic [N_GRP-1:0] stalled_q;

   for (genvar g = 0; g < N_GRP; g++) begin : g_slot
      localparam logic [ID_W-1:0] GID = ID_W'(g);

      logic            launch_hit;
      logic            done_hit;
      logic            exit_hit;
      logic            valid_d;
      logic            stalled_d;
      logic [PC_W-1:0] pc_d;

      always_comb begin
         launch_hit = launch_en && (launch_id == GID) && !valid_q[g];
         done_hit   = done_en && (done_id == GID);
         exit_hit   = done_hit && done_exit;

         valid_d = valid_q[g];
         if (launch_hit)    valid_d = 1'b1;
         else if (exit_hit) valid_d = 1'b0;

         stalled_d = stalled_q[g];
         if (launch_hit || exit_hit || wake_req[g]) stalled_d = 1'b0;
         else if (stall_req[g])                     stalled_d = 1'b1;

         pc_d = pc_q[g];
         if (launch_hit)    pc_d = launch_pc;
         else if (done_hit) pc_d = done_pc;

         elig_nxt[g] = valid_d && !stalled_d;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[g]   <= 1'b0;
            stalled_q[g] <= 1'b0;
            pc_q[g]      <= '0;
         end else begin
            valid_q[g]   <= valid_d;
            stalled_q[g] <= stalled_d;
            pc_q[g]      <= pc_d;
         end
      end

      a_r3_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
         wake_req[g] |=> !stalled_q[g]);

      a_r3_stall_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_q[g] && stall_req[g] && !wake_req[g] &&
          !(done_en && done_id == GID && done_exit)) |=> stalled_q[g]);

      a_r2_launch_loads: assert property (@(posedge clk) disable iff (!rst_n)
         (launch_en && launch_id == GID && !valid_q[g])
            |=> (valid_q[g] && !stalled_q[g] && pc_q[g] == $past(launch_pc)));

      a_r2_launch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (launch_en && launch_id == GID && valid_q[g] && !(done_en && done_id == GID))
            |=> (valid_q[g] && pc_q[g] == $past(pc_q[g])));

      a_r5_done_pc: assert property (@(posedge clk) disable iff (!rst_n)
         (done_en && done_id == GID && !done_exit) |=> (pc_q[g] == $past(done_pc)));
   end

endmodule

// File: rtl/qs_pick.sv
module qs_pick
   import qs_pkg::*;
#(
   parameter int         N_GRP = 8,
   parameter pick_mode_e MODE  = PICK_ROTATE,
   localparam int ID_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_GRP-1:0] elig,
   input  logic [ID_W-1:0]  base,
   output logic             found,
   output logic [ID_W-1:0]  pick
);

   if (MODE == PICK_ROTATE) begin : g_rotate
      always_comb begin
         found = 1'b0;
         pick  = base;
         for (int off = 1; off <= N_GRP; off++) begin
            int idx;
            idx = int'(base) + off;
            if (idx >= N_GRP) idx = idx - N_GRP;
            if (!found && elig[idx]) begin
               found = 1'b1;
               pick  = ID_W'(idx);
            end
         end
      end
   end else begin : g_lowest
      always_comb begin
         found = 1'b0;
         pick  = base;
         for (int idx = 0; idx < N_GRP; idx++) begin
            if (!found && elig[idx]) begin
               found = 1'b1;
               pick  = ID_W'(idx);
            end
         end
      end
   end

   a_r6_pick_is_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> elig[pick]);

   a_r8_none_found_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (elig == '0));

endmodule

// File: rtl/quad_sched.sv
module quad_sched
   import qs_pkg::*;
#(
   parameter int         N_GRP = 8,
   parameter int         PC_W  = 32,
   parameter pick_mode_e MODE  = PICK_ROTATE,
   localparam int ID_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_en,
   input  logic [ID_W-1:0]  launch_id,
   input  logic [PC_W-1:0]  launch_pc,
   input  logic [N_GRP-1:0] stall_req,
   input  logic [N_GRP-1:0] wake_req,
   input  logic             clause_done,
   input  logic [PC_W-1:0]  done_pc,
   input  logic             done_exit,
   output logic             run_valid,
   output logic [ID_W-1:0]  run_id,
   output logic [PC_W-1:0]  run_pc,
   output logic             idle
);

   if (N_GRP < 2 || N_GRP > 64) begin : g_bad_groups
      $error("quad_sched: N_GRP must lie in 2..64");
   end
   if (PC_W < 2 || PC_W > 64) begin : g_bad_pc
      $error("quad_sched: PC_W must lie in 2..64");
   end

   logic                       run_q;
   logic [ID_W-1:0]            cur_q;
   logic [N_GRP-1:0]           valid_q;
   logic [N_GRP-1:0][PC_W-1:0] pc_q;
   logic [N_GRP-1:0]           elig_nxt;
   logic                       done_en;
   logic                       decide;
   logic                       found;
   logic [ID_W-1:0]            pick;

   assign done_en = clause_done && run_q;
   assign decide  = !run_q || clause_done;

   qs_group_table #(.N_GRP(N_GRP), .PC_W(PC_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch_en (launch_en),
      .launch_id (launch_id),
      .launch_pc (launch_pc),
      .stall_req (stall_req),
      .wake_req  (wake_req),
      .done_en   (done_en),
      .done_id   (cur_q),
      .done_pc   (done_pc),
      .done_exit (done_exit),
      .valid_q   (valid_q),
      .pc_q      (pc_q),
      .elig_nxt  (elig_nxt)
   );

   qs_pick #(.N_GRP(N_GRP), .MODE(MODE)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .elig  (elig_nxt),
      .base  (cur_q),
      .found (found),
      .pick  (pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cur_q <= ID_W'(N_GRP - 1);
      end else if (decide) begin
         run_q <= found;
         if (found) cur_q <= pick;
      end
   end

   assign run_valid = run_q;
   assign run_id    = cur_q;
   assign run_pc    = run_q ? pc_q[cur_q] : '0;
   assign idle      = !run_q;

   a_r4_hold_mid_clause: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !clause_done) |=> (run_q && cur_q == $past(cur_q) && run_pc == $past(run_pc)));

   a_r5_running_is_resident: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> valid_q[cur_q]);

   a_r8_idle_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && elig_nxt != '0) |=> run_q);

   a_r7_sole_group_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && clause_done && elig_nxt == (N_GRP'(1) << cur_q))
         |=> (run_q && cur_q == $past(cur_q)));

   a_r1_idle_pc_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (run_pc == '0 && idle));

endmodule

// File: tb/quad_sched_test.sv
`timescale 1ns/1ps
module quad_sched_test;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch_en = 1'b0;
   logic [2:0]  launch_id = '0;
   logic [31:0] launch_pc = '0;
   logic [N-1:0] stall_req = '0;
   logic [N-1:0] wake_req = '0;
   logic        clause_done = 1'b0;
   logic [31:0] done_pc = '0;
   logic        done_exit = 1'b0;
   logic        run_valid;
   logic [2:0]  run_id;
   logic [31:0] run_pc;
   logic        idle;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   string       q_tag[$];
   bit          q_v[$];
   int          q_id[$];
   logic [31:0] q_pc[$];

   always #2.5 clk = ~clk;

   quad_sched uut (
      .clk(clk), .rst_n(rst_n),
      .launch_en(launch_en), .launch_id(launch_id), .launch_pc(launch_pc),
      .stall_req(stall_req), .wake_req(wake_req),
      .clause_done(clause_done), .done_pc(done_pc), .done_exit(done_exit),
      .run_valid(run_valid), .run_id(run_id), .run_pc(run_pc), .idle(idle)
   );

   task automatic tick(input string tag, input bit v, input int id, input logic [31:0] pc);
      q_tag.push_back(tag);
      q_v.push_back(v);
      q_id.push_back(id);
      q_pc.push_back(pc);
      @(posedge clk);
      @(negedge clk);
      launch_en   = 1'b0;
      stall_req   = '0;
      wake_req    = '0;
      clause_done = 1'b0;
      done_exit   = 1'b0;
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n && q_tag.size() > 0) begin
         string       t;
         bit          v;
         int          id;
         logic [31:0] pc;
         t  = q_tag.pop_front();
         v  = q_v.pop_front();
         id = q_id.pop_front();
         pc = q_pc.pop_front();
         compared++;
         if (run_valid !== v || idle !== !v || run_pc !== pc || (v && run_id !== 3'(id))) begin
            mismatched++;
            $display("FAIL %s: got valid=%0b idle=%0b id=%0d pc=%h, want valid=%0b id=%0d pc=%h",
                     t, run_valid, idle, run_id, run_pc, v, id, pc);
         end
      end
   end

   initial begin
      #(5.0 * 5000);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: got no end of run, want end within 5000 cycles");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      tick("R1 reset idle", 0, 0, 32'h0);
      // R2: launch group 2
      launch_en = 1; launch_id = 2; launch_pc = 32'd100;
      tick("R2 launch selects", 1, 2, 32'd100);
      // R4: launch of another group does not preempt
      launch_en = 1; launch_id = 5; launch_pc = 32'd500;
      tick("R4 no preempt on launch", 1, 2, 32'd100);
      // R2: relaunch of resident group ignored
      launch_en = 1; launch_id = 2; launch_pc = 32'd999;
      tick("R2 relaunch ignored", 1, 2, 32'd100);
      // R4: running group stalled keeps running
      stall_req[2] = 1;
      tick("R4 stalled mid clause", 1, 2, 32'd100);
      tick("R4 hold", 1, 2, 32'd100);
      // R6: boundary switches away from stalled group
      clause_done = 1; done_pc = 32'd140;
      tick("R6 leave stalled", 1, 5, 32'd500);
      // R6: same-cycle launch counts, rotation after 5 gives 7
      launch_en = 1; launch_id = 7; launch_pc = 32'd700;
      clause_done = 1; done_pc = 32'd520;
      tick("R6 rotate to 7", 1, 7, 32'd700);
      // R3/R6: wake 2, rotation wraps to 2 with its saved pc
      wake_req[2] = 1; clause_done = 1; done_pc = 32'd720;
      tick("R6 wrap to woken 2", 1, 2, 32'd140);
      // R3: stall and wake together on 5, wake wins
      stall_req[5] = 1; wake_req[5] = 1; clause_done = 1; done_pc = 32'd160;
      tick("R3 wake beats stall", 1, 5, 32'd520);
      // R5: exit group 5
      clause_done = 1; done_exit = 1; done_pc = 32'd0;
      tick("R5 exit moves on", 1, 7, 32'd720);
      // R7: only group 7 eligible, stays with new pc
      stall_req[2] = 1; clause_done = 1; done_pc = 32'd740;
      tick("R7 sole group stays", 1, 7, 32'd740);
      tick("R4 hold after stay", 1, 7, 32'd740);
      // R8: exit last eligible group -> idle
      clause_done = 1; done_exit = 1; done_pc = 32'd0;
      tick("R8 idle none eligible", 0, 0, 32'h0);
      // R8: clause_done while idle ignored
      clause_done = 1; done_pc = 32'd55;
      tick("R8 idle stays", 0, 0, 32'h0);
      // R8: wake from idle
      wake_req[2] = 1;
      tick("R8 wake from idle", 1, 2, 32'd160);
      // R5: exit makes idle
      clause_done = 1; done_exit = 1;
      tick("R5 exit to idle", 0, 0, 32'h0);
      // R2/R5: freed slot 5 relaunched
      launch_en = 1; launch_id = 5; launch_pc = 32'h1234;
      tick("R2 relaunch freed slot", 1, 5, 32'h1234);
      // R6: same-cycle stall at boundary counts -> idle
      stall_req[5] = 1; clause_done = 1; done_pc = 32'h1240;
      tick("R6 same-cycle stall", 0, 0, 32'h0);
      tick("R8 idle hold", 0, 0, 32'h0);
      // R3: wake restores with updated pc
      wake_req[5] = 1;
      tick("R3 wake resumes", 1, 5, 32'h1240);
      // R1: reset again clears everything
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      tick("R1 reset clears", 0, 0, 32'h0);
      @(posedge clk); #2;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule